// File: doc/BRIEF.md
# Chainable Periodic Down-Counter Timer Bank

This block holds a bank of periodic timers that share one tick input. Each timer holds a programmable reload value and a live down-counter. When the counter has reached zero, the next step reloads it and produces one expiry event, so a timer set to reload value B expires once every B+1 steps. A shared control word applies a power-of-two prescale to the tick. The same word can also chain any timer to its higher neighbour, which forms a wider counter whose top member alone signals expiry.

Every timer feeds a small tracker with two states, waiting and being serviced. The tracker's output is the timer's interrupt line. An acknowledge moves a waiting event into service, and an end-of-interrupt retires it. Any expiry that occurs while the previous event is waiting or being serviced is dropped without a trace. Software reaches every register over a plain single-cycle write bus with a combinational read. A self-clearing soft-reset bit returns the bank to its power-on state.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every reload register reads 0x8000_0000 (inhibit set, value zero), every live count reads 0, the control word reads 0, every vector/priority word reads 0x8000_0000 (mask set), every destination reads 1 and every irq is low.
- R2: With reload value B written and bit 31 (inhibit) clear, the first step loads B. Each following step decrements the count, and a step taken at zero reloads B and signals one expiry, so expiries repeat every B+1 steps.
- R3: The live-count register (slot 0) returns the count in its low CNT_W bits, and bit 31 holds a toggle that flips on every reload caused by expiry (not on the initial load).
- R4: While bit 31 of the reload register (slot 1) is set, the count holds its value and the timer never expires; the reload register reads back what was written.
- R5: Control bits [PRE_LSB+PRE_W-1:PRE_LSB] (bits 10:8 by default) hold p: timers step on one tick in every 2^p, and the first tick after any control write is a stepping tick.
- R6: Control bit i (i < N_TMR-1) chains timer i to timer i+1: timer i+1 steps only when timer i expires, and timer i raises no interrupt.
- R7: An expiry raises irq[i] (pending); irq_ack[i] while pending drops irq[i] and puts the event in service; irq_eoi[i] while in service retires it, and the next expiry raises irq[i] again.
- R8: An expiry that occurs while the previous event is pending or in service is discarded: irq stays low after the end-of-interrupt until a fresh expiry.
- R9: While vector/priority bit 31 (mask) is set the timer keeps counting but its expiries raise no event; clearing the mask does not recover an event that expired while masked.
- R10: Writing 1 to bit 0 of the global word (address 4*N_TMR+1) reads back 1 for one cycle, then the bank returns to the R1 state and the bit reads 0.
- R11: Timer i's registers sit at address 4*i + slot (0 live count, 1 reload, 2 vector/priority with priority at bits 19:16 and vector at bits 15:0, 3 destination); the control word sits at 4*N_TMR; written fields read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | $clog2(4*N_TMR)+1 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick | input | 1 | Shared timer tick, one cycle per pulse |
| irq_ack | input | N_TMR | Per-timer acknowledge |
| irq_eoi | input | N_TMR | Per-timer end-of-interrupt |
| irq | output | N_TMR | Per-timer interrupt (pending) |

## Verification
The bench builds the bank with four timers and CNT_W set to 8. This brings a full reload sweep, including the maximum value 255 and the wraparound at B+1 steps, within a few thousand cycles. With the narrow counters, every reload value from 0 to 15 can be checked tick by tick against an arithmetic model of count, toggle and first expiry. It also makes a two-timer chain and prescales of 1 and 2 short enough to check to the exact tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W  = 32;
  localparam int FLAG_BIT = 31;
  localparam int VEC_W   = 16;
  localparam int PRI_W   = 4;
  localparam int PRI_LSB = 16;
  localparam int PRE_LSB = 8;

  typedef enum logic [1:0] {
    SLOT_COUNT  = 2'd0,
    SLOT_BASE   = 2'd1,
    SLOT_VECPRI = 2'd2,
    SLOT_DEST   = 2'd3
  } slot_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [PRE_W-1:0] shift,
  output logic             step
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] pc_q, pc_d, lim;

  always_comb begin
    lim  = (PC_W'(1) << shift) - PC_W'(1);
    step = tick && (pc_q == '0);
    pc_d = pc_q;
    if (restart) begin
      pc_d = '0;
    end else if (tick) begin
      pc_d = (pc_q == lim) ? '0 : pc_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // With a non-zero prescale, two stepping ticks never come back to back.
  assert_step_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && shift != '0 && !restart) |=> !step);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int CNT_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step_en,
  input  logic              base_we,
  input  logic [DATA_W-1:0] base_wdata,
  output logic [DATA_W-1:0] base_rd,
  output logic [DATA_W-1:0] cnt_rd,
  output logic              wrap
);
  logic [CNT_W-1:0] base_q, base_d, cnt_q, cnt_d;
  logic             inh_q, inh_d, tgl_q, tgl_d, load_q, load_d;

  assign wrap = step_en && !inh_q && !load_q && (cnt_q == '0);

  always_comb begin
    base_d = base_q;
    inh_d  = inh_q;
    cnt_d  = cnt_q;
    tgl_d  = tgl_q;
    load_d = load_q;
    if (step_en && !inh_q) begin
      if (load_q) begin
        cnt_d  = base_q;
        load_d = 1'b0;
      end else if (cnt_q == '0) begin
        cnt_d = base_q;
        tgl_d = !tgl_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (base_we) begin
      base_d = base_wdata[CNT_W-1:0];
      inh_d  = base_wdata[FLAG_BIT];
      load_d = !base_wdata[FLAG_BIT];
    end
    if (clr) begin
      base_d = '0;
      inh_d  = 1'b1;
      cnt_d  = '0;
      tgl_d  = 1'b0;
      load_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      inh_q  <= 1'b1;
      cnt_q  <= '0;
      tgl_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      base_q <= base_d;
      inh_q  <= inh_d;
      cnt_q  <= cnt_d;
      tgl_q  <= tgl_d;
      load_q <= load_d;
    end
  end

  always_comb begin
    cnt_rd                = '0;
    cnt_rd[CNT_W-1:0]     = cnt_q;
    cnt_rd[FLAG_BIT]      = tgl_q;
    base_rd               = '0;
    base_rd[CNT_W-1:0]    = base_q;
    base_rd[FLAG_BIT]     = inh_q;
  end

  assert_hold_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && !clr) |=> $stable(cnt_q));
  assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !base_we && !clr) |=> (cnt_q == $past(base_q)));
  assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !clr) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/tmr_irq_track.sv
module tmr_irq_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic expire,
  input  logic mask,
  input  logic ack,
  input  logic eoi,
  output logic pend,
  output logic insv
);
  logic pend_q, pend_d, insv_q, insv_d, evt;

  assign evt  = expire && !mask;
  assign pend = pend_q;
  assign insv = insv_q;

  always_comb begin
    pend_d = pend_q;
    insv_d = insv_q;
    if (ack && pend_q) begin
      pend_d = 1'b0;
      insv_d = 1'b1;
    end
    if (eoi && insv_q) begin
      insv_d = 1'b0;
    end
    if (evt && !pend_q && !insv_q) begin
      pend_d = 1'b1;
    end
    if (clr) begin
      pend_d = 1'b0;
      insv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      insv_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      insv_q <= insv_d;
    end
  end

  assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ack && !clr) |=> (insv_q && !pend_q));
  assert_drop_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    insv_q |=> !pend_q);
  assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !pend_q) |=> !pend_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank import tmr_pkg::*; #(
  parameter int N_TMR  = 4,
  parameter int CNT_W  = 31,
  parameter int PRE_W  = 3,
  parameter int DEST_W = 4,
  localparam int ADDR_W = $clog2(4*N_TMR) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic [N_TMR-1:0]  irq_ack,
  input  logic [N_TMR-1:0]  irq_eoi,
  output logic [N_TMR-1:0]  irq
);
  localparam int TS_W      = ADDR_W - 3;
  localparam int CTRL_ADDR = 4 * N_TMR;
  localparam int GCFG_ADDR = 4 * N_TMR + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // address decode
  logic            in_tmr, ctrl_we, gcfg_we;
  logic [TS_W-1:0] tsel;
  slot_e           slot;
  assign in_tmr  = (bus_addr < ADDR_W'(CTRL_ADDR));
  assign tsel    = bus_addr[ADDR_W-2:2];
  assign slot    = slot_e'(bus_addr[1:0]);
  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign gcfg_we = bus_we && (bus_addr == ADDR_W'(GCFG_ADDR));

  // shared control, soft reset and per-timer configuration
  logic [N_TMR-2:0]  casc_q, casc_d;
  logic [PRE_W-1:0]  shift_q, shift_d;
  logic              srst_q, srst_d, clr;
  logic [VEC_W-1:0]  vec_q  [N_TMR];
  logic [VEC_W-1:0]  vec_d  [N_TMR];
  logic [PRI_W-1:0]  pri_q  [N_TMR];
  logic [PRI_W-1:0]  pri_d  [N_TMR];
  logic [DEST_W-1:0] dest_q [N_TMR];
  logic [DEST_W-1:0] dest_d [N_TMR];
  logic [N_TMR-1:0]  mask_q, mask_d;

  assign clr = srst_q;

  always_comb begin
    casc_d  = casc_q;
    shift_d = shift_q;
    mask_d  = mask_q;
    srst_d  = gcfg_we && bus_wdata[0] && !srst_q;
    for (int i = 0; i < N_TMR; i++) begin
      vec_d[i]  = vec_q[i];
      pri_d[i]  = pri_q[i];
      dest_d[i] = dest_q[i];
      if (bus_we && in_tmr && tsel == TS_W'(i)) begin
        if (slot == SLOT_VECPRI) begin
          vec_d[i]  = bus_wdata[VEC_W-1:0];
          pri_d[i]  = bus_wdata[PRI_LSB +: PRI_W];
          mask_d[i] = bus_wdata[FLAG_BIT];
        end
        if (slot == SLOT_DEST) begin
          dest_d[i] = bus_wdata[DEST_W-1:0];
        end
      end
    end
    if (ctrl_we) begin
      casc_d  = bus_wdata[N_TMR-2:0];
      shift_d = bus_wdata[PRE_LSB +: PRE_W];
    end
    if (clr) begin
      casc_d  = '0;
      shift_d = '0;
      mask_d  = '1;
      for (int i = 0; i < N_TMR; i++) begin
        vec_d[i]  = '0;
        pri_d[i]  = '0;
        dest_d[i] = DEST_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      casc_q  <= '0;
      shift_q <= '0;
      mask_q  <= '1;
      srst_q  <= 1'b0;
      for (int i = 0; i < N_TMR; i++) begin
        vec_q[i]  <= '0;
        pri_q[i]  <= '0;
        dest_q[i] <= DEST_W'(1);
      end
    end else begin
      casc_q  <= casc_d;
      shift_q <= shift_d;
      mask_q  <= mask_d;
      srst_q  <= srst_d;
      for (int i = 0; i < N_TMR; i++) begin
        vec_q[i]  <= vec_d[i];
        pri_q[i]  <= pri_d[i];
        dest_q[i] <= dest_d[i];
      end
    end
  end

  // tick prescale
  logic step;
  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (ctrl_we || clr),
    .tick    (tick),
    .shift   (shift_q),
    .step    (step)
  );

  // timers and trackers
  logic [N_TMR-1:0]  step_en, wrap, expire, base_we, insv;
  logic [DATA_W-1:0] cnt_rd  [N_TMR];
  logic [DATA_W-1:0] base_rd [N_TMR];

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    if (i == 0) begin : g_head
      assign step_en[i] = step;
    end else begin : g_link
      assign step_en[i] = casc_q[i-1] ? wrap[i-1] : step;
    end
    if (i == N_TMR - 1) begin : g_top
      assign expire[i] = wrap[i];
    end else begin : g_low
      assign expire[i] = wrap[i] && !casc_q[i];
      assert_chained_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        casc_q[i] |=> !$rose(irq[i]));
    end

    assign base_we[i] = bus_we && in_tmr && (tsel == TS_W'(i)) && (slot == SLOT_BASE);

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .clr        (clr),
      .step_en    (step_en[i]),
      .base_we    (base_we[i]),
      .base_wdata (bus_wdata),
      .base_rd    (base_rd[i]),
      .cnt_rd     (cnt_rd[i]),
      .wrap       (wrap[i])
    );

    tmr_irq_track u_trk (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr    (clr),
      .expire (expire[i]),
      .mask   (mask_q[i]),
      .ack    (irq_ack[i]),
      .eoi    (irq_eoi[i]),
      .pend   (irq[i]),
      .insv   (insv[i])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (in_tmr) begin
      for (int i = 0; i < N_TMR; i++) begin
        if (tsel == TS_W'(i)) begin
          case (slot)
            SLOT_COUNT: bus_rdata = cnt_rd[i];
            SLOT_BASE:  bus_rdata = base_rd[i];
            SLOT_VECPRI: begin
              bus_rdata[VEC_W-1:0]         = vec_q[i];
              bus_rdata[PRI_LSB +: PRI_W]  = pri_q[i];
              bus_rdata[FLAG_BIT]          = mask_q[i];
            end
            default:    bus_rdata[DEST_W-1:0] = dest_q[i];
          endcase
        end
      end
    end else if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[N_TMR-2:0]         = casc_q;
      bus_rdata[PRE_LSB +: PRE_W]  = shift_q;
    end else if (bus_addr == ADDR_W'(GCFG_ADDR)) begin
      bus_rdata[0] = srst_q;
    end
  end

  assert_srst_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srst_q |=> !srst_q);
  assert_srst_quiets_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srst_q |=> (irq == '0 && insv == '0));
  assert_serviced_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq & insv) == '0);
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int AW = $clog2(4*N) + 1;
  localparam int CTRL = 4*N;
  localparam int GCFG = 4*N + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          tick = 1'b0;
  logic [N-1:0]  ack = '0;
  logic [N-1:0]  eoi = '0;
  logic [N-1:0]  irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tmr_bank #(.N_TMR(N), .CNT_W(CW), .PRE_W(3), .DEST_W(4)) u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .irq_ack(ack), .irq_eoi(eoi), .irq(irq)
  );

  function automatic int adr(int t, int s);
    return 4*t + s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); ack = '1;
    @(negedge clk); ack = '0; eoi = '1;
    @(negedge clk); eoi = '0;
  endtask

  task automatic pulse(bit is_eoi, int t);
    @(negedge clk);
    if (is_eoi) eoi[t] = 1'b1; else ack[t] = 1'b1;
    @(negedge clk);
    eoi = '0; ack = '0;
  endtask

  initial begin
    logic [31:0] v, e;
    logic        t0;
    int          s, bb, t;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(adr(0,1), v); chk("R1 reload", v, 32'h8000_0000);
    rd(adr(3,0), v); chk("R1 count", v, 32'h0);
    rd(CTRL, v);     chk("R1 control", v, 32'h0);
    rd(adr(1,2), v); chk("R1 mask", v, 32'h8000_0000);
    rd(adr(2,3), v); chk("R1 dest", v, 32'h1);
    chk("R1 irq", 32'(irq), 32'h0);

    // R11 unmask and read back vector/priority, destination
    for (int i = 0; i < N; i++) begin
      wr(adr(i,2), 32'h0003_0010 + 32'(i));
      rd(adr(i,2), v); chk("R11 vecpri", v, 32'h0003_0010 + 32'(i));
    end
    wr(adr(2,3), 32'h5);
    rd(adr(2,3), v); chk("R11 dest", v, 32'h5);

    // R2 R3 reload sweep
    for (int b = 0; b <= 16; b++) begin
      t  = b % N;
      bb = (b == 16) ? 255 : b;
      wr(adr(t,1), 32'h8000_0000);
      clear_irq();
      rd(adr(t,0), v); t0 = v[31];
      wr(adr(t,1), 32'(bb));
      for (int k = 1; k <= 2*(bb+1)+2; k++) begin
        tk();
        s = k - 1;
        e = '0;
        e[CW-1:0] = CW'(bb - (s % (bb+1)));
        e[31] = t0 ^ (((s / (bb+1)) % 2) == 1);
        rd(adr(t,0), v); chk("R2 R3 count", v, e);
        chk("R2 expiry", 32'(irq[t]), 32'(s >= bb+1));
      end
      wr(adr(t,1), 32'h8000_0000 | 32'(bb));
    end

    // R4 inhibit
    clear_irq();
    wr(adr(0,1), 32'd3);
    tk(); tk();
    wr(adr(0,1), 32'h8000_0003);
    rd(adr(0,1), v); chk("R4 reload readback", v, 32'h8000_0003);
    rd(adr(0,0), v); chk("R4 count before", 32'(v[7:0]), 32'd2);
    repeat (5) tk();
    rd(adr(0,0), v); chk("R4 count held", 32'(v[7:0]), 32'd2);
    chk("R4 no expiry", 32'(irq[0]), 32'h0);

    // R7 R8 tracker and lost events
    wr(adr(1,1), 32'd0);
    tk(); chk("R7 idle", 32'(irq[1]), 32'h0);
    tk(); chk("R7 pending", 32'(irq[1]), 32'h1);
    repeat (3) tk();
    chk("R8 still one pending", 32'(irq[1]), 32'h1);
    pulse(1'b0, 1); chk("R7 ack drops irq", 32'(irq[1]), 32'h0);
    repeat (3) tk();
    chk("R8 lost while in service", 32'(irq[1]), 32'h0);
    pulse(1'b1, 1); chk("R8 nothing queued", 32'(irq[1]), 32'h0);
    tk(); chk("R7 fresh expiry", 32'(irq[1]), 32'h1);
    wr(adr(1,1), 32'h8000_0000);

    // R9 mask
    wr(adr(2,2), 32'h8003_0012);
    wr(adr(2,1), 32'h8000_0000);
    clear_irq();
    wr(adr(2,1), 32'd1);
    for (int k = 0; k < 6; k++) begin
      tk(); chk("R9 masked quiet", 32'(irq[2]), 32'h0);
    end
    rd(adr(2,0), v); chk("R9 still counting", 32'(v[7:0]), 32'h0);
    wr(adr(2,2), 32'h0003_0012);
    chk("R9 no stale event", 32'(irq[2]), 32'h0);
    tk(); chk("R9 unmasked expiry", 32'(irq[2]), 32'h1);
    wr(adr(2,1), 32'h8000_0000);

    // R6 cascade
    clear_irq();
    wr(CTRL, 32'h1);
    wr(adr(0,1), 32'd2);
    wr(adr(1,1), 32'd3);
    for (int k = 1; k <= 16; k++) begin
      tk();
      if (k == 7) begin
        rd(adr(1,0), v); chk("R6 upper count", 32'(v[7:0]), 32'd2);
      end
      if (k == 15) chk("R6 upper early", 32'(irq[1]), 32'h0);
      chk("R6 lower silent", 32'(irq[0]), 32'h0);
    end
    chk("R6 upper expiry", 32'(irq[1]), 32'h1);
    wr(adr(0,1), 32'h8000_0000);
    wr(adr(1,1), 32'h8000_0000);

    // R5 prescale
    wr(CTRL, 32'h100);
    clear_irq();
    wr(adr(2,1), 32'd1);
    tk(); tk();
    rd(adr(2,0), v); chk("R5 p1 skipped tick", 32'(v[7:0]), 32'd1);
    tk(); tk();
    rd(adr(2,0), v); chk("R5 p1 count", 32'(v[7:0]), 32'd0);
    chk("R5 p1 early", 32'(irq[2]), 32'h0);
    tk(); chk("R5 p1 expiry", 32'(irq[2]), 32'h1);
    wr(adr(2,1), 32'h8000_0000);
    wr(CTRL, 32'h200);
    rd(CTRL, v); chk("R5 control readback", v, 32'h200);
    clear_irq();
    wr(adr(2,1), 32'd0);
    repeat (4) tk();
    chk("R5 p2 early", 32'(irq[2]), 32'h0);
    tk(); chk("R5 p2 expiry", 32'(irq[2]), 32'h1);

    // R10 soft reset (irq[2] pending going in)
    wr(GCFG, 32'h1);
    rd(GCFG, v); chk("R10 bit set", v, 32'h1);
    @(negedge clk);
    rd(GCFG, v); chk("R10 self clear", v, 32'h0);
    chk("R10 irq", 32'(irq), 32'h0);
    rd(adr(2,1), v); chk("R10 reload", v, 32'h8000_0000);
    rd(adr(2,2), v); chk("R10 mask", v, 32'h8000_0000);
    rd(adr(2,3), v); chk("R10 dest", v, 32'h1);
    rd(CTRL, v);     chk("R10 control", v, 32'h0);
    rd(adr(0,0), v); chk("R10 count", v, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule